// File: doc/BRIEF.md
# Frame-level configuration selector

This block picks one hardware configuration for each media frame before the frame runs. When a frame starts, it forecasts how many instructions the frame will retire. The forecast is the largest retired count among the recent completed frames of the same frame type, plus a programmable margin. The block then walks a configuration table from the cheapest entry to the dearest and stops at the first entry whose instruction budget covers the forecast.

Software fills the table through a simple write port. Entries must be stored in order of increasing energy per instruction. Each entry carries an instruction budget (the most instructions the configuration can retire before the deadline) and an energy-per-instruction figure. The chosen index, its energy figure and a done flag stay steady for the whole frame. If nothing fits, the entry with the biggest budget is used and a no-fit flag is raised.

Top module: `frame_cfg_picker`

## Requirements
- R1: After reset, `done`, `busy` and `no_fit` are 0 and `cfg_idx` is 0.
- R2: A table write with `tbl_we` high stores `tbl_max` and `tbl_epi` at `tbl_addr`. When that entry is chosen, `cfg_epi` shows its stored energy figure.
- R3: The forecast is the maximum of the last five retired counts logged for the frame's type, plus `leeway`. The sum saturates at all ones of the counter width.
- R4: Types 0, 1 and 2 each keep their own history. A `frame_end` pulse logs `end_count` into the history of the type given by the most recently accepted frame start.
- R5: Entry j is examined in the j-th clock after the start. The first entry whose budget is greater than or equal to the forecast is chosen. If `frame_start` is sampled at edge k and entry j is chosen, `done` is high after edge k+1+j.
- R6: If no entry fits, the entry with the largest budget is chosen (the lowest index among ties), `no_fit` is 1, and `done` is high after edge k+`tbl_len`.
- R7: With fewer than five logged frames, only the logged ones count. With none, the largest-budget entry is chosen and `no_fit` is 0.
- R8: Once `done` is high, `cfg_idx`, `cfg_epi`, `no_fit` and `done` hold until the next accepted start. `busy` and `done` are never high together, and a `frame_start` while `busy` is ignored.
- R9: Only entries 0 to `tbl_len`-1 are examined. Entries at or above `tbl_len` are never chosen.
- R10: A `frame_start` with type code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Frame start strobe |
| frame_type | input | 2 | Frame type code (0, 1, 2 valid) |
| frame_end | input | 1 | Frame completion strobe |
| end_count | input | 16 | Retired instruction count of the completed frame |
| leeway | input | 16 | Additive forecast margin |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 6 | Table write index |
| tbl_max | input | 16 | Instruction budget to write |
| tbl_epi | input | 16 | Energy-per-instruction figure to write |
| tbl_len | input | 7 | Number of valid table entries |
| cfg_idx | output | 6 | Chosen configuration index |
| cfg_epi | output | 16 | Energy figure of the chosen entry |
| done | output | 1 | Selection complete and held |
| no_fit | output | 1 | No entry covered the forecast |
| busy | output | 1 | Scan in progress |

## Verification
The table is filled with budgets that are not monotonic in index, and it ends with duplicate maxima. A large entry is placed just beyond `tbl_len`. This shows apart a correct first-fit from a best-fit, a wrong tie rule and an out-of-range scan. Frames rotate through the three types with varied counts, so forecasts land below, between and above the budgets. Along the way a type's history fills, then ages out its oldest value, which tells a five-deep window from a longer or shorter one. A huge margin tells saturation from wraparound. Pulses during a scan and pulses with code 3 show that only valid idle starts are taken. Latency is measured on every frame to pin down the one-entry-per-clock scan order.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
  typedef enum logic {SC_IDLE, SC_SCAN} scan_state_e;
endpackage

// File: rtl/fcp_history.sv
module fcp_history #(
  parameter int CW    = 16,
  parameter int NT    = 3,
  parameter int DEPTH = 5,
  parameter int TW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          log_en,
  input  logic [TW-1:0] log_type,
  input  logic [CW-1:0] log_count,
  input  logic [TW-1:0] rd_type,
  input  logic [CW-1:0] leeway,
  output logic [CW-1:0] pred,
  output logic          pred_valid
);
  // saturating forecast sum
  function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CW] ? {CW{1'b1}} : s[CW-1:0];
  endfunction

  logic [NT-1:0][CW-1:0] tmax;
  logic [NT-1:0]         tany;

  for (genvar t = 0; t < NT; t++) begin : g_type
    logic [CW-1:0]    h [DEPTH];
    logic [DEPTH-1:0] v;
    logic [CW-1:0]    m;
    logic             hit;

    assign hit = log_en && (log_type == TW'(t));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v <= '0;
        for (int d = 0; d < DEPTH; d++) h[d] <= '0;
      end else if (hit) begin
        h[0] <= log_count;
        for (int d = 1; d < DEPTH; d++) h[d] <= h[d-1];
        v <= {v[DEPTH-2:0], 1'b1};
      end
    end

    always_comb begin
      m = '0;
      for (int d = 0; d < DEPTH; d++)
        if (v[d] && (h[d] > m)) m = h[d];
    end

    assign tmax[t] = m;
    assign tany[t] = |v;
  end

  assign pred       = sat_add(tmax[rd_type], leeway);
  assign pred_valid = tany[rd_type];
endmodule

// File: rtl/fcp_table.sv
module fcp_table #(
  parameter int CW = 16,
  parameter int EW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [CW-1:0] wmax,
  input  logic [EW-1:0] wepi,
  input  logic [AW-1:0] scan_idx,
  output logic [CW-1:0] scan_max,
  input  logic [AW-1:0] pick_idx,
  output logic [EW-1:0] pick_epi
);
  localparam int ENT = 1 << AW;

  logic [CW-1:0] mx [ENT];
  logic [EW-1:0] ep [ENT];

  always_ff @(posedge clk) begin
    if (we) begin
      mx[waddr] <= wmax;
      ep[waddr] <= wepi;
    end
  end

  assign scan_max = mx[scan_idx];
  assign pick_epi = ep[pick_idx];
endmodule

// File: rtl/fcp_scan.sv
module fcp_scan
  import fcp_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] pred_in,
  input  logic          pred_ok_in,
  input  logic [AW:0]   tbl_len,
  input  logic [CW-1:0] ent_max,
  output logic [AW-1:0] rd_idx,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] pick_idx,
  output logic          no_fit,
  output logic          finish_evt
);
  scan_state_e   st;
  logic [AW-1:0] idx, best_idx, len_m1;
  logic [CW-1:0] best_max, pred_q;
  logic          pv_q, hit, bigger, last;

  function automatic logic entry_fits(input logic ok, input logic [CW-1:0] cap,
                                      input logic [CW-1:0] need);
    return ok && (cap >= need);
  endfunction

  assign len_m1     = (tbl_len == '0) ? '0 : AW'(tbl_len - 1'b1);
  assign hit        = (st == SC_SCAN) && entry_fits(pv_q, ent_max, pred_q);
  assign bigger     = (idx == '0) || (ent_max > best_max);
  assign last       = (idx == len_m1);
  assign finish_evt = (st == SC_SCAN) && (hit || last);
  assign rd_idx     = idx;
  assign busy       = (st == SC_SCAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SC_IDLE;
      idx      <= '0;
      best_idx <= '0;
      best_max <= '0;
      pred_q   <= '0;
      pv_q     <= 1'b0;
      pick_idx <= '0;
      no_fit   <= 1'b0;
      done     <= 1'b0;
    end else begin
      unique case (st)
        SC_IDLE: begin
          if (go) begin
            st       <= SC_SCAN;
            idx      <= '0;
            best_idx <= '0;
            best_max <= '0;
            pred_q   <= pred_in;
            pv_q     <= pred_ok_in;
            done     <= 1'b0;
            no_fit   <= 1'b0;
          end
        end
        SC_SCAN: begin
          if (bigger) begin
            best_max <= ent_max;
            best_idx <= idx;
          end
          if (hit) begin
            pick_idx <= idx;
            no_fit   <= 1'b0;
            done     <= 1'b1;
            st       <= SC_IDLE;
          end else if (last) begin
            pick_idx <= bigger ? idx : best_idx;
            no_fit   <= pv_q;
            done     <= 1'b1;
            st       <= SC_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= SC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_cfg_picker.sv
module frame_cfg_picker #(
  parameter int CW    = 16,
  parameter int EW    = 16,
  parameter int AW    = 6,
  parameter int NT    = 3,
  parameter int DEPTH = 5,
  localparam int TW   = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic [TW-1:0] frame_type,
  input  logic          frame_end,
  input  logic [CW-1:0] end_count,
  input  logic [CW-1:0] leeway,
  input  logic          tbl_we,
  input  logic [AW-1:0] tbl_addr,
  input  logic [CW-1:0] tbl_max,
  input  logic [EW-1:0] tbl_epi,
  input  logic [AW:0]   tbl_len,
  output logic [AW-1:0] cfg_idx,
  output logic [EW-1:0] cfg_epi,
  output logic          done,
  output logic          no_fit,
  output logic          busy
);
  localparam logic [TW:0] NT_W = (TW+1)'(NT);

  logic [TW-1:0] cur_type;
  logic [CW-1:0] pred, ent_max;
  logic          pred_ok, accept, finish_evt;
  logic [AW-1:0] scan_idx;

  assign accept = frame_start && !busy && ({1'b0, frame_type} < NT_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_type <= '0;
    else if (accept) cur_type <= frame_type;
  end

  fcp_history #(.CW(CW), .NT(NT), .DEPTH(DEPTH), .TW(TW)) hist_i (
    .clk(clk), .rst_n(rst_n),
    .log_en(frame_end), .log_type(cur_type), .log_count(end_count),
    .rd_type(frame_type), .leeway(leeway),
    .pred(pred), .pred_valid(pred_ok)
  );

  fcp_table #(.CW(CW), .EW(EW), .AW(AW)) tbl_i (
    .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wmax(tbl_max), .wepi(tbl_epi),
    .scan_idx(scan_idx), .scan_max(ent_max),
    .pick_idx(cfg_idx), .pick_epi(cfg_epi)
  );

  fcp_scan #(.CW(CW), .AW(AW)) scan_i (
    .clk(clk), .rst_n(rst_n), .go(accept),
    .pred_in(pred), .pred_ok_in(pred_ok), .tbl_len(tbl_len),
    .ent_max(ent_max), .rd_idx(scan_idx), .busy(busy), .done(done),
    .pick_idx(cfg_idx), .no_fit(no_fit), .finish_evt(finish_evt)
  );
endmodule

// File: rtl/fcp_chk.sv
module fcp_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          finish_evt,
  input logic          busy,
  input logic          done,
  input logic          no_fit,
  input logic [AW-1:0] cfg_idx,
  input logic [AW:0]   tbl_len
);
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && !done);

  assert_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> done && !busy);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !accept) |=> done && $stable(cfg_idx) && $stable(no_fit));

  assert_nofit_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    no_fit |-> done);

  assert_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (tbl_len != '0)) |-> ({1'b0, cfg_idx} < tbl_len));
endmodule

bind frame_cfg_picker fcp_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .accept(accept), .finish_evt(finish_evt),
  .busy(busy), .done(done), .no_fit(no_fit), .cfg_idx(cfg_idx), .tbl_len(tbl_len)
);

// File: tb/frame_cfg_picker_tb_top.sv
module frame_cfg_picker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [1:0]  frame_type = '0;
  logic        frame_end = 1'b0;
  logic [15:0] end_count = '0;
  logic [15:0] leeway = '0;
  logic        tbl_we = 1'b0;
  logic [5:0]  tbl_addr = '0;
  logic [15:0] tbl_max = '0;
  logic [15:0] tbl_epi = '0;
  logic [6:0]  tbl_len = '0;
  logic [5:0]  cfg_idx;
  logic [15:0] cfg_epi;
  logic        done, no_fit, busy;

  int tests = 0;
  int fails = 0;

  int mtab [64];
  int etab [64];
  int hist [3][5];
  int hcnt [3];
  int lw = 0;
  int len = 0;

  frame_cfg_picker dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_type(frame_type),
    .frame_end(frame_end), .end_count(end_count), .leeway(leeway),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_max(tbl_max), .tbl_epi(tbl_epi),
    .tbl_len(tbl_len), .cfg_idx(cfg_idx), .cfg_epi(cfg_epi),
    .done(done), .no_fit(no_fit), .busy(busy)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put_entry(input int a, input int mx, input int ep);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 6'(a); tbl_max = 16'(mx); tbl_epi = 16'(ep);
    mtab[a] = mx; etab[a] = ep;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // reference forecast and choice, restated from the requirements
  task automatic predict(input int t, output int eidx, output bit enf, output int elat);
    int mx, p, best, bidx;
    bit ok;
    ok = hcnt[t] > 0;
    mx = 0;
    for (int d = 0; d < hcnt[t]; d++) if (hist[t][d] > mx) mx = hist[t][d];
    p = mx + lw;
    if (p > 65535) p = 65535;
    best = -1; bidx = 0;
    for (int j = 0; j < len; j++) begin
      if (ok && mtab[j] >= p) begin
        eidx = j; enf = 1'b0; elat = j + 2;
        return;
      end
      if (mtab[j] > best) begin best = mtab[j]; bidx = j; end
    end
    eidx = bidx; enf = ok; elat = len + 1;
  endtask

  task automatic log_model(input int t, input int c);
    for (int d = 4; d > 0; d--) hist[t][d] = hist[t][d-1];
    hist[t][0] = c;
    if (hcnt[t] < 5) hcnt[t]++;
  endtask

  task automatic do_frame(input int t, input int c, input bit poke, input string req);
    int eidx, elat, n;
    bit enf;
    predict(t, eidx, enf, elat);
    @(negedge clk);
    frame_start = 1'b1; frame_type = 2'(t);
    @(negedge clk);
    frame_start = 1'b0;
    n = 1;
    while (!done && n < 200) begin
      if (poke && n == 2) begin
        frame_start = 1'b1; frame_type = 2'((t + 1) % 3);
      end else begin
        frame_start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    frame_start = 1'b0;
    chk(req, "latency (R5/R6)", n, elat);
    chk(req, "cfg_idx", cfg_idx, eidx);
    chk(req, "no_fit (R6/R7)", no_fit, enf);
    chk("R2", "cfg_epi", cfg_epi, etab[eidx]);
    chk("R8", "busy low at done", busy, 0);
    frame_end = 1'b1; end_count = 16'(c);
    @(negedge clk);
    frame_end = 1'b0;
    log_model(t, c);
  endtask

  initial begin
    #1000000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [5:0] held;
    for (int t = 0; t < 3; t++) hcnt[t] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done", done, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "no_fit", no_fit, 0);
    chk("R1", "cfg_idx", cfg_idx, 0);

    put_entry(0, 100, 5);
    put_entry(1, 300, 15);
    put_entry(2, 250, 25);
    put_entry(3, 800, 35);
    put_entry(4, 600, 45);
    put_entry(5, 1200, 55);
    put_entry(6, 1000, 65);
    put_entry(7, 1200, 75);
    put_entry(8, 60000, 85);   // beyond tbl_len: R9
    len = 8; tbl_len = 7'd8;
    lw = 20; leeway = 16'd20;

    do_frame(0, 90, 0, "R7");     // no history: largest budget, first tie
    do_frame(0, 500, 0, "R3");    // 110 -> entry 1
    do_frame(0, 70, 0, "R3");     // 520 -> entry 3
    do_frame(1, 1190, 0, "R4");   // type 1 has its own empty history
    do_frame(1, 10, 0, "R9");     // 1210: no fit, entry 8 ignored
    do_frame(2, 1100, 0, "R7");
    for (int i = 0; i < 5; i++) do_frame(2, 10 + i, 0, "R3");   // 1100 ages out
    do_frame(2, 10, 0, "R3");

    for (int i = 0; i < 30; i++) do_frame(i % 3, (i * 377 + 123) % 1400, 0, "R5");

    do_frame(1, 200, 1, "R8");    // start pulse during scan ignored

    // R10: type code 3 ignored while holding a selection
    held = cfg_idx;
    @(negedge clk);
    frame_start = 1'b1; frame_type = 2'd3;
    @(negedge clk);
    frame_start = 1'b0;
    chk("R10", "busy after code 3", busy, 0);
    chk("R10", "done after code 3", done, 1);
    chk("R10", "cfg_idx after code 3", cfg_idx, held);
    repeat (4) @(negedge clk);
    chk("R8", "cfg_idx held", cfg_idx, held);
    chk("R8", "done held", done, 1);

    // R3 saturation: budget of all ones fits only if the sum saturates
    put_entry(7, 65535, 95);
    lw = 65520; leeway = 16'hFFF0;
    do_frame(0, 50, 0, "R3");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule